// File: doc/BRIEF.md
# CPU Clock Retune Sequencer

This block retunes a processor clock to a requested frequency at or below 1 GHz without glitching it. The clock tree it controls has two parallel paths. Each path has a source selector (premux), an integer divider and a postmux that bypasses the divider. A final dynamic select picks one of the two paths, and a final PLL select overrides both. The sequencer holds the 32-bit control word that drives those cells. It always reprograms the path that is not currently selected, and only then moves the dynamic select over to that path. The running clock therefore never sees a half-updated path.

A request is a one-cycle `req_valid` pulse carrying a target frequency in Hz. The block searches for a divisor of a 2 GHz base one step per clock. It keeps only divisors that contain a pre-divide of 2 or 3, because that pre-divide cannot be bypassed. The pre-divide picks the fixed source: 1 GHz for a pre-divide of 2, 666 MHz for a pre-divide of 3. The remaining factor goes into the path divider. Settle waits of a parameterised number of cycles follow the source change and the final switch. The block ends every request with a one-cycle `done` or `error` pulse.

Top module: `cpu_clk_retune`

## Requirements
- R1: After reset, `ctrl_word` equals the parameter `RESET_WORD`, and `done`, `error` and `busy` are all low.
- R2: The divisor is the smallest integer D of 2 or more for which floor(2e9 / D) does not exceed the target. D is then raised to the next value that is divisible by 2 or by 3.
- R3: An even D selects source code 1 (1 GHz) and a path divisor of D/2. An odd D selects source code 2 (666 MHz) and a path divisor of D/3. The divider field holds the path divisor minus 1.
- R4: When control bit 10 (dynamic select) is 1 at the start of a request, path 0 is programmed: source in bits [1:0], postmux enable in bit 2, divider in bits [9:4]. Bits 10 and 11 are then both cleared, and the path-1 fields are left unchanged.
- R5: When bit 10 is 0 at the start of a request, path 1 is programmed: source in bits [17:16], postmux enable in bit 18, divider in bits [25:20]. Bit 10 is then set and bit 11 cleared, and the path-0 fields are left unchanged.
- R6: The postmux enable of the programmed path is set exactly when the path divisor is not 1.
- R7: Bit 26 (divider-load enable) rises for exactly one cycle before the new divider count is written. It is low in the final word.
- R8: At least `SETTLE_CYCLES` cycles pass between the source change and the next change of the control word. At least `SETTLE_CYCLES` cycles also pass between the final select change and `done`.
- R9: If D exceeds 32, `error` pulses for one cycle and `ctrl_word` stays unchanged.
- R10: `done` is a single-cycle pulse. A `req_valid` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_freq | input | 32 | Target frequency in Hz |
| ctrl_word | output | 32 | Clock control register image |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse: retune finished |
| error | output | 1 | One-cycle pulse: request rejected |

## Verification
The assertions check on every cycle the properties that can be stated without knowing the request. These are the one-cycle shapes of `done`, `error` and the divider-load bit, the settle spacing after a source change and before completion, and the rule that a rejected request and an idle block leave the word alone. Only the bench scenarios can show that the chosen source code, divider count, postmux bit and path match the target frequency. The bench drives a scoreboard with several targets: exact fixed-source values, odd and even searches, the largest accepted divisor, values just outside the range, and a request issued while the block is busy.

// File: rtl/cpu_clk_retune.sv
module cpu_clk_retune #(
  parameter logic [31:0] RESET_WORD    = 32'h0000_0C00,
  parameter int          SETTLE_CYCLES = 4,
  parameter longint      BASE_HZ       = 64'd2000000000,
  parameter int          MAX_DIV       = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_freq,
  output logic [31:0] ctrl_word,
  output logic        busy,
  output logic        done,
  output logic        error
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam int DW = $clog2(MAX_DIV + 2);

  typedef enum logic [3:0] {
    S_IDLE, S_SEARCH, S_ALIGN, S_PREMUX, S_WAIT_PM,
    S_LOAD_EN, S_DIV_WR, S_POST, S_FINAL, S_WAIT_FIN
  } state_t;

  state_t        state;
  logic [31:0]   target;
  logic [DW-1:0] dv;
  logic          use_p1;
  logic [CW-1:0] wait_cnt;

  logic          dv_even, dv_ok, step_more;
  logic [5:0]    sub_div, cnt_val;
  logic [1:0]    src_code;

  assign busy      = (state != S_IDLE);
  assign dv_even   = ~dv[0];
  assign dv_ok     = dv_even || ((dv % 3) == 0);
  assign step_more = (longint'(dv) * (longint'(target) + 1)) <= BASE_HZ;
  assign sub_div   = 6'(dv_even ? (dv >> 1) : (dv / 3));
  assign cnt_val   = sub_div - 6'd1;
  assign src_code  = dv_even ? 2'd1 : 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ctrl_word <= RESET_WORD;
      target    <= '0;
      dv        <= '0;
      use_p1    <= 1'b0;
      wait_cnt  <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          target <= req_freq;
          dv     <= DW'(2);
          use_p1 <= ~ctrl_word[10];
          state  <= S_SEARCH;
        end
        S_SEARCH:
          if (dv > DW'(MAX_DIV) || !step_more) state <= S_ALIGN;
          else dv <= dv + 1'b1;
        S_ALIGN:
          if (!dv_ok) dv <= dv + 1'b1;
          else if (dv > DW'(MAX_DIV)) begin
            error <= 1'b1;
            state <= S_IDLE;
          end else state <= S_PREMUX;
        S_PREMUX: begin
          if (use_p1) ctrl_word[17:16] <= src_code;
          else        ctrl_word[1:0]   <= src_code;
          wait_cnt <= CW'(SETTLE_CYCLES - 1);
          state    <= S_WAIT_PM;
        end
        S_WAIT_PM:
          if (wait_cnt == '0) state <= S_LOAD_EN;
          else wait_cnt <= wait_cnt - 1'b1;
        S_LOAD_EN: begin
          ctrl_word[26] <= 1'b1;
          state         <= S_DIV_WR;
        end
        S_DIV_WR: begin
          ctrl_word[26] <= 1'b0;
          if (use_p1) ctrl_word[25:20] <= cnt_val;
          else        ctrl_word[9:4]   <= cnt_val;
          state <= S_POST;
        end
        S_POST: begin
          if (use_p1) ctrl_word[18] <= (sub_div != 6'd1);
          else        ctrl_word[2]  <= (sub_div != 6'd1);
          state <= S_FINAL;
        end
        S_FINAL: begin
          ctrl_word[10] <= use_p1;
          ctrl_word[11] <= 1'b0;
          wait_cnt      <= CW'(SETTLE_CYCLES - 1);
          state         <= S_WAIT_FIN;
        end
        S_WAIT_FIN:
          if (wait_cnt == '0) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else wait_cnt <= wait_cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cpu_clk_retune_chk.sv
module cpu_clk_retune_chk #(
  parameter int SETTLE_CYCLES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ctrl_word,
  input logic        busy,
  input logic        done,
  input logic        error
);
  logic [31:0] prev_word;
  logic [15:0] pm_age, fin_age;
  logic        pm_chg, fin_chg, word_chg;

  assign pm_chg   = (ctrl_word[1:0] != prev_word[1:0]) || (ctrl_word[17:16] != prev_word[17:16]);
  assign fin_chg  = ctrl_word[11:10] != prev_word[11:10];
  assign word_chg = ctrl_word != prev_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_word <= ctrl_word;
      pm_age    <= '1;
      fin_age   <= '1;
    end else begin
      prev_word <= ctrl_word;
      pm_age    <= pm_chg  ? 16'd1 : (pm_age  == '1 ? pm_age  : pm_age  + 1'b1);
      fin_age   <= fin_chg ? 16'd1 : (fin_age == '1 ? fin_age : fin_age + 1'b1);
    end
  end

  assert_single_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_load_en_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[26] |=> !ctrl_word[26]);
  assert_error_keeps_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> $stable(ctrl_word));
  assert_premux_settle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_chg && !pm_chg) |-> (32'(pm_age) >= 32'(SETTLE_CYCLES)));
  assert_final_settle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (32'(fin_age) >= 32'(SETTLE_CYCLES)));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(ctrl_word));
  assert_pll_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ctrl_word[11] && !ctrl_word[26]);
endmodule

bind cpu_clk_retune cpu_clk_retune_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
  .busy(busy), .done(done), .error(error)
);

// File: tb/cpu_clk_retune_test.sv
module cpu_clk_retune_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 4;
  localparam logic [31:0] RST_WORD = 32'h0000_0C00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_freq = '0;
  logic [31:0] ctrl_word;
  logic        busy, done, error;

  int checks = 0, errors = 0, resp_cnt = 0, en_high = 0, lat = 0;
  logic [31:0] exp_word_q[$];
  bit          exp_err_q[$];
  logic [31:0] model_word;

  cpu_clk_retune #(.RESET_WORD(RST_WORD), .SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_freq(req_freq),
    .ctrl_word(ctrl_word), .busy(busy), .done(done), .error(error));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference from the requirements (R2, R3, R4, R5, R6, R9)
  task automatic predict(input int unsigned f, output logic [31:0] w, output bit err);
    longint d = 2;
    int sd;
    logic [1:0] code;
    w = model_word;
    while (d <= 33 && (64'd2000000000 / d) > longint'(f)) d++;
    while ((d % 2) != 0 && (d % 3) != 0) d++;
    err = (d > 32);
    if (err) return;
    if (d % 2 == 0) begin code = 2'd1; sd = int'(d / 2); end
    else            begin code = 2'd2; sd = int'(d / 3); end
    if (w[10]) begin
      w[1:0] = code; w[9:4] = 6'(sd - 1); w[2] = (sd != 1); w[11:10] = 2'b00;
    end else begin
      w[17:16] = code; w[25:20] = 6'(sd - 1); w[18] = (sd != 1); w[10] = 1'b1; w[11] = 1'b0;
    end
    w[26] = 1'b0;
  endtask

  task automatic run(input int unsigned f, input bit poke_busy);
    logic [31:0] w; bit e; int n;
    while (busy) @(negedge clk);
    predict(f, w, e);
    exp_word_q.push_back(w); exp_err_q.push_back(e);
    if (!e) model_word = w;
    n = resp_cnt;
    req_freq = f; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke_busy) begin
      @(negedge clk); @(negedge clk);
      check(busy == 1'b1, "R10 busy during request", 32'(busy), 32'd1);
      req_freq = 32'd1000000000; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (resp_cnt == n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) lat++;
      if (ctrl_word[26]) en_high++;
      if (done || error) begin
        if (exp_word_q.size() == 0) begin
          check(1'b0, "R10 unexpected response", 32'(done), 32'd0);
        end else begin
          logic [31:0] ew; bit ee;
          ew = exp_word_q.pop_front(); ee = exp_err_q.pop_front();
          check(error == ee && done == !ee, "R9 outcome kind", {30'd0, done, error}, {30'd0, !ee, ee});
          check(ctrl_word == ew, "R2 R3 R4 R5 R6 control word", ctrl_word, ew);
          if (!ee) begin
            check(en_high == 1, "R7 load-enable pulse width", 32'(en_high), 32'd1);
            check(lat >= 2 * SETTLE, "R8 settle latency", 32'(lat), 32'(2 * SETTLE));
          end
        end
        resp_cnt++;
        en_high = 0;
        lat = 0;
      end
    end
  end

  initial begin
    model_word = RST_WORD;
    repeat (3) @(negedge clk);
    check(ctrl_word == RST_WORD, "R1 reset word", ctrl_word, RST_WORD);
    check({done, error, busy} == 3'b000, "R1 reset flags", {29'd0, done, error, busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 idle after reset", 32'(busy), 32'd0);

    run(32'd1000000000, 1'b0);   // R4 path0, divisor 1, postmux off (R6)
    run(32'd500000000,  1'b0);   // R5 path1
    run(32'd666666666,  1'b0);   // R3 odd source
    run(32'd100000000,  1'b0);   // R2 longer search
    run(32'd70000000,   1'b0);   // R2 align 29 -> 30
    run(32'd60000000,   1'b0);   // R9 divisor above limit
    run(32'd62500000,   1'b0);   // R2 largest accepted divisor 32
    run(32'd0,          1'b0);   // R9 zero target
    run(32'd400000000,  1'b1);   // R10 request while busy ignored
    run(32'd222222222,  1'b0);   // R3 divide-by-3 with divider 3

    repeat (10) @(negedge clk);
    check(exp_word_q.size() == 0, "R10 responses balanced", 32'(exp_word_q.size()), 32'd0);
    check(ctrl_word == model_word, "R10 word after ignored request", ctrl_word, model_word);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule